// File: doc/BRIEF.md
# CAN Transmit Frame Queue with Commit-on-Write

This block is the transmit side frame store of a CAN controller. Software builds one frame at a time by writing four word-wide registers: an identifier word, a length-code word and two data words. These words are held in staging registers until a commit write arrives. The commit write pushes the whole frame into a first-in first-out queue of parameterised depth. Which write commits depends on the frame type. A remote request is committed by the length-code write and carries no data. A data frame is committed by the second data-word write.

The protocol engine sees the oldest queued frame on a set of parallel outputs, qualified by a valid flag. It returns a one-cycle "sent" pulse when that frame has gone out on the bus. The block drives a full flag in a status word. It also raises one-cycle event pulses for transmit done, queue became full and queue drained. A sticky overflow flag records a commit that was dropped because the queue was full. A synchronous soft reset empties the queue, clears the overflow flag and discards any staged words.

Top module: `cantxq_top`

## Requirements
- R1: After reset the queue is empty: `frm_valid`, the full flag, the overflow flag and every event bit read 0.
- R2: A data frame is committed only on the write to offset 0x3C (second data word). It is presented with the staged identifier, the length code from bits 31:28 of the offset 0x34 write, the offset 0x38 word and the offset 0x3C word. Before that write `frm_valid` stays 0.
- R3: A frame is a remote request when identifier bit 19 is 1 and bit 0 is 1, or when bit 19 is 0 and bit 20 is 1. A remote request is committed on the offset 0x34 write, with both data words presented as zero.
- R4: While the staged identifier is a remote request, writes to offset 0x3C commit nothing. An extended identifier (bit 19 = 1) with bit 0 clear is a data frame even when bit 20 is set.
- R5: Frames leave in the order they were committed. `status_word[10]` is 1 exactly while the queue holds DEPTH frames.
- R6: A commit while the queue is full, with no pop in the same cycle, is dropped. The queue contents stay unchanged and `ovf_flag` rises and stays 1 until soft reset.
- R7: A `sent_pulse` while a frame is queued removes the head frame and gives `irq_evt[1]` for one cycle in the next cycle. A `sent_pulse` on an empty queue has no effect and no event.
- R8: `irq_evt[14]` pulses for one cycle when the last queued frame is removed with no commit in the same cycle.
- R9: `irq_evt[2]` pulses for one cycle when the queue reaches DEPTH frames from below.
- R10: A commit and a `sent_pulse` in the same cycle on a full queue both take effect: the head is removed, the new frame is appended, and no overflow is flagged.
- R11: `soft_rst` empties the queue, clears `ovf_flag` and clears the staged identifier, length and first data word to zero.
- R12: Writes to offsets other than 0x30, 0x34, 0x38 and 0x3C change nothing. All bits of `status_word` and `irq_evt` other than 10, 1, 2 and 14 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of queue, staging and overflow flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| sent_pulse | input | 1 | Engine reports the head frame was transmitted |
| frm_valid | output | 1 | A frame is queued and presented |
| frm_id | output | 32 | Identifier word of the head frame |
| frm_len | output | 4 | Length code of the head frame |
| frm_dw1 | output | 32 | First data word of the head frame |
| frm_dw2 | output | 32 | Second data word of the head frame |
| status_word | output | 16 | Bit 10: queue full |
| irq_evt | output | 16 | One-cycle events: bit 1 done, bit 2 became full, bit 14 drained |
| ovf_flag | output | 1 | Sticky dropped-commit flag |

## Verification
Two functions can fall in the same cycle: a commit write to the second data word and a sent pulse from the engine. When this happens on a full queue, the block must decide whether the commit overflows. The bench fills the queue to depth, stages a third data frame, and then drives the offset 0x3C write and `sent_pulse` on the same clock edge. It judges the result by the overflow flag staying low, the full flag staying high, a done event without a full event, and the third frame appearing at the head after two more pops.

// File: rtl/cantxq_pkg.sv
package cantxq_pkg;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  len;
        logic [31:0] dw1;
        logic [31:0] dw2;
    } txq_frame_t;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  len;
        logic [31:0] dw1;
    } txq_stage_t;

    localparam logic [7:0] OFS_ID  = 8'h30;
    localparam logic [7:0] OFS_LEN = 8'h34;
    localparam logic [7:0] OFS_DW1 = 8'h38;
    localparam logic [7:0] OFS_DW2 = 8'h3C;

    localparam int STAT_FULL_BIT = 10;
    localparam int EVT_DONE_BIT  = 1;
    localparam int EVT_FULL_BIT  = 2;
    localparam int EVT_EMPTY_BIT = 14;

    localparam int ID_EXT_BIT  = 19;
    localparam int ID_SRR_BIT  = 20;
    localparam int ID_RTR_BIT  = 0;

    // Remote request: extended uses bit 0, base format uses bit 20
    function automatic logic is_remote(input logic [31:0] id);
        return id[ID_EXT_BIT] ? id[ID_RTR_BIT] : id[ID_SRR_BIT];
    endfunction

endpackage

// File: rtl/cantxq_stage.sv
module cantxq_stage
    import cantxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        commit,
    output txq_frame_t  commit_frame
);

    txq_stage_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        commit       = 1'b0;
        commit_frame = '0;
        if (soft_rst) begin
            st_d = '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFS_ID: begin
                    st_d.id = wr_data;
                end
                OFS_LEN: begin
                    st_d.len = wr_data[31:28];
                    if (is_remote(st_q.id)) begin
                        commit           = 1'b1;
                        commit_frame.id  = st_q.id;
                        commit_frame.len = wr_data[31:28];
                    end
                end
                OFS_DW1: begin
                    st_d.dw1 = wr_data;
                end
                OFS_DW2: begin
                    if (!is_remote(st_q.id)) begin
                        commit           = 1'b1;
                        commit_frame.id  = st_q.id;
                        commit_frame.len = st_q.len;
                        commit_frame.dw1 = st_q.dw1;
                        commit_frame.dw2 = wr_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cantxq_store.sv
module cantxq_store
    import cantxq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  txq_frame_t       push_frame,
    input  logic             pop,
    output logic             accepted,
    output logic             popped,
    output logic [CNT_W-1:0] count,
    output txq_frame_t       head
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t    q_d, q_q;
    txq_frame_t mem [DEPTH];

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d      = q_q;
        popped   = pop && !clr && (q_q.cnt != '0);
        accepted = push && !clr && ((q_q.cnt != CNT_W'(DEPTH)) || popped);
        if (clr) begin
            q_d = '0;
        end else begin
            if (accepted) q_d.wr = adv(q_q.wr);
            if (popped)   q_d.rd = adv(q_q.rd);
            case ({accepted, popped})
                2'b10:   q_d.cnt = q_q.cnt + 1'b1;
                2'b01:   q_d.cnt = q_q.cnt - 1'b1;
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (accepted) begin
            mem[q_q.wr] <= push_frame;
        end
    end

    assign count = q_q.cnt;
    assign head  = mem[q_q.rd];

endmodule

// File: rtl/cantxq_flags.sv
module cantxq_flags #(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push_try,
    input  logic             accepted,
    input  logic             popped,
    input  logic [CNT_W-1:0] cnt_q,
    output logic             evt_done,
    output logic             evt_full,
    output logic             evt_empty,
    output logic             ovf
);

    typedef struct packed {
        logic done;
        logic full;
        logic empty;
        logic ovf;
    } flags_t;

    flags_t           f_d, f_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        case ({accepted, popped})
            2'b10:   cnt_nx = cnt_q + 1'b1;
            2'b01:   cnt_nx = cnt_q - 1'b1;
            default: cnt_nx = cnt_q;
        endcase
        f_d = '0;
        if (!clr) begin
            f_d.done  = popped;
            f_d.full  = (cnt_nx == CNT_W'(DEPTH)) && (cnt_q != CNT_W'(DEPTH));
            f_d.empty = popped && !accepted && (cnt_q == CNT_W'(1));
            f_d.ovf   = f_q.ovf || (push_try && !accepted);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign evt_done  = f_q.done;
    assign evt_full  = f_q.full;
    assign evt_empty = f_q.empty;
    assign ovf       = f_q.ovf;

endmodule

// File: rtl/cantxq_top.sv
module cantxq_top
    import cantxq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        sent_pulse,
    output logic        frm_valid,
    output logic [31:0] frm_id,
    output logic [3:0]  frm_len,
    output logic [31:0] frm_dw1,
    output logic [31:0] frm_dw2,
    output logic [15:0] status_word,
    output logic [15:0] irq_evt,
    output logic        ovf_flag
);

    logic             commit, accepted, popped;
    txq_frame_t       commit_frame, head;
    logic [CNT_W-1:0] count;
    logic             evt_done, evt_full, evt_empty;

    cantxq_stage u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .commit       (commit),
        .commit_frame (commit_frame)
    );

    cantxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .push       (commit),
        .push_frame (commit_frame),
        .pop        (sent_pulse),
        .accepted   (accepted),
        .popped     (popped),
        .count      (count),
        .head       (head)
    );

    cantxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .push_try  (commit),
        .accepted  (accepted),
        .popped    (popped),
        .cnt_q     (count),
        .evt_done  (evt_done),
        .evt_full  (evt_full),
        .evt_empty (evt_empty),
        .ovf       (ovf_flag)
    );

    assign frm_valid = (count != '0);
    assign frm_id    = head.id;
    assign frm_len   = head.len;
    assign frm_dw1   = head.dw1;
    assign frm_dw2   = head.dw2;

    always_comb begin
        status_word                = '0;
        status_word[STAT_FULL_BIT] = (count == CNT_W'(DEPTH));
        irq_evt                    = '0;
        irq_evt[EVT_DONE_BIT]      = evt_done;
        irq_evt[EVT_FULL_BIT]      = evt_full;
        irq_evt[EVT_EMPTY_BIT]     = evt_empty;
    end

endmodule

// File: rtl/cantxq_chk.sv
module cantxq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        sent_pulse,
    input logic        frm_valid,
    input logic [15:0] status_word,
    input logic [15:0] irq_evt,
    input logic        ovf_flag
);

    // R11: soft reset leaves nothing queued and no overflow
    a_r11_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!frm_valid && !ovf_flag));

    // R5: full implies a frame is presented
    a_r5_full_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[10] |-> frm_valid);

    // R8: drained event leaves nothing presented
    a_r8_empty_evt_drained: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt[14] |-> !frm_valid);

    // R7: done event only after a sent pulse on a non-empty queue
    a_r7_done_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt[1] |-> ($past(sent_pulse) && $past(frm_valid)));

    // R9: full event coincides with the full status bit
    a_r9_full_evt_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt[2] |-> status_word[10]);

    // R6: overflow is sticky until soft reset
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !soft_rst) |=> ovf_flag);

    // R12: unused status and event bits stay low
    a_r12_unused_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_word & ~16'h0400) == 16'h0) && ((irq_evt & ~16'h4006) == 16'h0));

endmodule

bind cantxq_top cantxq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .sent_pulse  (sent_pulse),
    .frm_valid   (frm_valid),
    .status_word (status_word),
    .irq_evt     (irq_evt),
    .ovf_flag    (ovf_flag)
);

// File: tb/tb_cantxq_top.sv
module tb_cantxq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sent_pulse = 1'b0;
    logic        frm_valid;
    logic [31:0] frm_id;
    logic [3:0]  frm_len;
    logic [31:0] frm_dw1;
    logic [31:0] frm_dw2;
    logic [15:0] status_word;
    logic [15:0] irq_evt;
    logic        ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cantxq_top dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sent_pulse(sent_pulse),
        .frm_valid(frm_valid), .frm_id(frm_id), .frm_len(frm_len),
        .frm_dw1(frm_dw1), .frm_dw2(frm_dw2), .status_word(status_word),
        .irq_evt(irq_evt), .ovf_flag(ovf_flag)
    );

    // {remote_expected, id, len, dw1, dw2}
    localparam logic [100:0] VEC [6] = '{
        {1'b0, 32'h24600000, 4'h8, 32'h11223344, 32'h55667788},
        {1'b1, 32'hFFF00000, 4'h3, 32'hAAAA0001, 32'hBBBB0002},
        {1'b0, 32'h14B82468, 4'h5, 32'hDEADBEEF, 32'h0BADF00D},
        {1'b1, 32'h3C18ABC1, 4'h0, 32'h01010101, 32'h02020202},
        {1'b0, 32'h20000001, 4'h2, 32'hCAFE0000, 32'h0000CAFE},
        {1'b0, 32'h00080000, 4'h1, 32'h13579BDF, 32'h2468ACE0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic sent();
        @(negedge clk);
        sent_pulse = 1'b1;
        @(negedge clk);
        sent_pulse = 1'b0;
    endtask

    task automatic sreset();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic data_frame(input logic [31:0] id, input logic [3:0] len,
                              input logic [31:0] d1, input logic [31:0] d2);
        wr(8'h30, id);
        wr(8'h34, {len, 28'h0});
        wr(8'h38, d1);
        wr(8'h3C, d2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'b0, frm_valid}, 32'h0);
        chk("R1 status", {16'b0, status_word}, 32'h0);
        chk("R1 events", {16'b0, irq_evt}, 32'h0);
        chk("R1 ovf", {31'b0, ovf_flag}, 32'h0);

        // Table walk: R2 R3 R4 R7 R8
        for (int i = 0; i < 6; i++) begin
            logic        rem;
            logic [31:0] id, d1, d2;
            logic [3:0]  ln;
            {rem, id, ln, d1, d2} = VEC[i];
            wr(8'h30, id);
            wr(8'h34, {ln, 28'h0});
            if (rem) begin
                chk("R3 remote commit on length", {31'b0, frm_valid}, 32'h1);
                chk("R3 remote id", frm_id, id);
                chk("R3 remote len", {28'b0, frm_len}, {28'b0, ln});
                chk("R3 remote dw1 zero", frm_dw1, 32'h0);
                chk("R3 remote dw2 zero", frm_dw2, 32'h0);
                wr(8'h38, d1);
                wr(8'h3C, d2);
            end else begin
                wr(8'h38, d1);
                chk("R2 no commit before dw2", {31'b0, frm_valid}, 32'h0);
                wr(8'h3C, d2);
                chk("R2 data commit", {31'b0, frm_valid}, 32'h1);
                chk("R2 id", frm_id, id);
                chk("R2 len", {28'b0, frm_len}, {28'b0, ln});
                chk("R2 dw1", frm_dw1, d1);
                chk("R2 dw2", frm_dw2, d2);
            end
            sent();
            chk("R7 done event", {31'b0, irq_evt[1]}, 32'h1);
            chk("R8 empty event", {31'b0, irq_evt[14]}, 32'h1);
            chk("R4 single frame only", {31'b0, frm_valid}, 32'h0);
        end

        // R7: sent on empty queue ignored
        sent();
        chk("R7 no done on empty", {16'b0, irq_evt}, 32'h0);
        chk("R7 still empty", {31'b0, frm_valid}, 32'h0);

        // R5 R9: fill to depth
        data_frame(32'h00200000, 4'h1, 32'hA1, 32'hA2);
        chk("R5 not full at one", {31'b0, status_word[10]}, 32'h0);
        data_frame(32'h00400000, 4'h2, 32'hB1, 32'hB2);
        chk("R5 full at depth", {31'b0, status_word[10]}, 32'h1);
        chk("R9 full event", {31'b0, irq_evt[2]}, 32'h1);
        chk("R5 head is first", frm_dw1, 32'hA1);

        // R6: overflow
        data_frame(32'h00600000, 4'h3, 32'hC1, 32'hC2);
        chk("R6 ovf set", {31'b0, ovf_flag}, 32'h1);
        chk("R6 head unchanged", frm_dw1, 32'hA1);
        sent();
        chk("R5 order second", frm_dw1, 32'hB1);
        chk("R6 ovf sticky", {31'b0, ovf_flag}, 32'h1);
        sent();
        chk("R6 dropped frame absent", {31'b0, frm_valid}, 32'h0);
        chk("R8 empty after drain", {31'b0, irq_evt[14]}, 32'h1);

        // R11: soft reset clears queue, ovf, staging
        data_frame(32'h00800000, 4'h4, 32'hD1, 32'hD2);
        wr(8'h30, 32'h12345678);
        wr(8'h34, 32'h70000000);
        wr(8'h38, 32'h9ABCDEF0);
        sreset();
        chk("R11 queue empty", {31'b0, frm_valid}, 32'h0);
        chk("R11 ovf cleared", {31'b0, ovf_flag}, 32'h0);
        wr(8'h3C, 32'h0000BEEF);
        chk("R11 staged id cleared", frm_id, 32'h0);
        chk("R11 staged len cleared", {28'b0, frm_len}, 32'h0);
        chk("R11 staged dw1 cleared", frm_dw1, 32'h0);
        chk("R11 new dw2", frm_dw2, 32'h0000BEEF);
        sreset();

        // R10: commit and sent in same cycle on a full queue
        data_frame(32'h00A00000, 4'h1, 32'hE1, 32'hE2);
        data_frame(32'h00C00000, 4'h2, 32'hF1, 32'hF2);
        wr(8'h30, 32'h00E00000);
        wr(8'h34, 32'h30000000);
        wr(8'h38, 32'h000000C1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h3C; wr_data = 32'h000000C2; sent_pulse = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; sent_pulse = 1'b0;
        chk("R10 no overflow", {31'b0, ovf_flag}, 32'h0);
        chk("R10 still full", {31'b0, status_word[10]}, 32'h1);
        chk("R10 done event", {31'b0, irq_evt[1]}, 32'h1);
        chk("R10 no full event", {31'b0, irq_evt[2]}, 32'h0);
        chk("R10 head advanced", frm_dw1, 32'hF1);
        sent();
        chk("R10 new frame queued", frm_dw1, 32'hC1);
        chk("R10 new frame dw2", frm_dw2, 32'hC2);
        sent();
        chk("R10 drained", {31'b0, irq_evt[14]}, 32'h1);

        // R12: other offsets ignored
        wr(8'h30, 32'h00400000);
        wr(8'h40, 32'hFFFFFFFF);
        wr(8'h2C, 32'hFFFFFFFF);
        wr(8'h3D, 32'h11111111);
        chk("R12 no commit on stray offsets", {31'b0, frm_valid}, 32'h0);
        wr(8'h34, 32'h60000000);
        wr(8'h38, 32'h0000AB01);
        wr(8'h3C, 32'h0000AB02);
        chk("R12 id untouched", frm_id, 32'h00400000);
        chk("R12 len untouched", {28'b0, frm_len}, 32'h6);
        sent();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule